// File: doc/BRIEF.md
# Preamble Beacon Vote Detector

This block finds a beacon preamble in an energy-collection receiver. For every received symbol it gets one 4-bit energy sample from each of eight integrators. It picks the integrator that holds the largest sample and adds one vote to that integrator's counter. When several integrators share the largest value, it chooses among them pseudo-randomly. After a fixed window of symbols, it compares the highest vote count with a programmable threshold. If the count is above the threshold, the block raises a one-cycle beacon-detect pulse.

The winner of every symbol is reported as a 3-bit index and as a one-hot vector. The block declares synchronisation after its second detection, and sync then stays set until reset. Bit decisions and the framing that follows synchronisation belong to the blocks that use these outputs.

Top module: `beacon_vote_detector`

## Requirements
- R1: After a synchronous active-low reset, `win_valid`, `win_idx`, `win_onehot`, `beacon_det` and `sync_locked` are all 0. The tie-break register is loaded with 8'hA5 and the vote window starts empty.
- R2: Lane i's sample is `sym_samples[4*i+3:4*i]`. When one lane holds a strictly larger sample than every other lane, that lane's index is the winner.
- R3: When n lanes share the maximum, let r be the current tie-break value and k = r mod n. The winner is the k-th tied lane, counting from 0 in ascending index order.
- R4: The tie-break register is an 8-bit shift register. Its next value is {r[6:0], r[7]^r[5]^r[4]^r[3]}. It steps once per accepted symbol, after its current value has been used. In a cycle with `sym_valid` low, nothing advances and the winner outputs hold their values.
- R5: One cycle after a symbol is accepted, `win_valid` is 1 for exactly one cycle and `win_idx` holds the winner. `win_onehot` has exactly bit `win_idx` set.
- R6: A window holds 40 accepted symbols. In the cycle after its 40th symbol, `beacon_det` pulses for one cycle if the highest vote count, including that last symbol's vote, is strictly greater than `vote_threshold`. A count equal to the threshold does not detect.
- R7: All vote counters start from zero in each new window, so votes from one window never carry into the next.
- R8: `sync_locked` rises in the same cycle as the second `beacon_det` pulse since reset, whether or not the two detections come from consecutive windows. It then stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_valid | input | 1 | One symbol's samples are present this cycle |
| sym_samples | input | 32 | Eight 4-bit integrator samples; lane i at bits 4i+3..4i |
| vote_threshold | input | 6 | Detection threshold; the winning count must exceed it |
| win_valid | output | 1 | One-cycle pulse marking a new winner |
| win_idx | output | 3 | Index of the most recent winner |
| win_onehot | output | 8 | One-hot form of `win_idx` |
| beacon_det | output | 1 | One-cycle pulse when a window ends with a detection |
| sync_locked | output | 1 | Set at the second detection; held until reset |

## Verification
The hardest situation to reach is a tie that the tie-break rule must settle while the vote counts also sit on the threshold boundary. To reach the boundary, directed windows keep one lane at the top for all 40 symbols, with the threshold at 39 (detects) and then at 40 (does not detect). To exercise ties, random windows draw samples from a narrow range of high values so that two to eight lanes tie often, and one window holds all lanes at zero. Idle cycles are mixed in throughout, so a tie-break sequence that advanced on idle cycles would send later winners away from the bench's model.

// File: rtl/bvd_pkg.sv
// Package: shared constants and the registered winner record for the beacon
// vote detector. Assumes a fixed lane count of eight with 4-bit samples.
package bvd_pkg;
    localparam int unsigned NLANE  = 8;
    localparam int unsigned SAMP_W = 4;
    localparam int unsigned IDX_W  = $clog2(NLANE);
    localparam int unsigned RND_W  = 8;
    localparam int unsigned TIE_W  = $clog2(NLANE + 1);

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic [NLANE-1:0] onehot;
    } win_t;
endpackage

// File: rtl/bvd_lfsr.sv
// Module: 8-bit Fibonacci shift register that supplies the tie-break value.
// It steps only when adv is high, so idle cycles leave the sequence untouched.
// Assumes the seed is non-zero.
module bvd_lfsr
    import bvd_pkg::*;
#(
    parameter logic [RND_W-1:0] SEED = 8'hA5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [RND_W-1:0] state
);
    logic fb;

    // Feedback taps for a maximal-length 8-bit sequence.
    always_comb fb = state[7] ^ state[5] ^ state[4] ^ state[3];

    // Load the seed on reset; otherwise shift once per accepted symbol.
    always_ff @(posedge clk) begin
        if (!rst_n)   state <= SEED;
        else if (adv) state <= {state[RND_W-2:0], fb};
    end

    // R4: idle cycles do not move the sequence.
    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(state));
    // R4: a maximal sequence never enters the all-zero lock-up state.
    p_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);
endmodule

// File: rtl/bvd_argmax.sv
// Module: combinational arg-max over eight samples. It reports the mask of
// lanes that equal the maximum, and picks one of them: with n tied lanes,
// the pick is the (rnd mod n)-th tied lane in ascending index order.
module bvd_argmax
    import bvd_pkg::*;
(
    input  logic [NLANE*SAMP_W-1:0] samples,
    input  logic [RND_W-1:0]        rnd,
    output logic [NLANE-1:0]        tie_mask,
    output logic [IDX_W-1:0]        pick
);
    logic [SAMP_W-1:0] max_val;
    logic [TIE_W-1:0]  n_tied;
    logic [RND_W-1:0]  k_sel;
    logic [TIE_W-1:0]  seen;
    logic              found;

    // Find the largest sample value over all lanes.
    always_comb begin
        max_val = '0;
        for (int i = 0; i < NLANE; i++) begin
            if (samples[i*SAMP_W +: SAMP_W] > max_val)
                max_val = samples[i*SAMP_W +: SAMP_W];
        end
    end

    // Mark the lanes that equal the maximum and count them.
    always_comb begin
        n_tied = '0;
        for (int i = 0; i < NLANE; i++) begin
            tie_mask[i] = (samples[i*SAMP_W +: SAMP_W] == max_val);
            n_tied      = n_tied + TIE_W'(tie_mask[i]);
        end
    end

    // Reduce the random value modulo the tie count, then walk to that lane.
    always_comb begin
        k_sel = (n_tied == '0) ? '0 : (rnd % RND_W'(n_tied));
        seen  = '0;
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < NLANE; i++) begin
            if (tie_mask[i]) begin
                if (!found && (RND_W'(seen) == k_sel)) begin
                    pick  = IDX_W'(i);
                    found = 1'b1;
                end
                seen = seen + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bvd_vote_bank.sv
// Module: one vote counter per lane. It adds one vote to the lane named by
// inc_onehot and clears all counters when the window closes. max_next is the
// highest count including this cycle's vote, for the window decision.
// Assumes no more than WINDOW votes arrive between clears.
module bvd_vote_bank
    import bvd_pkg::*;
#(
    parameter int unsigned WINDOW = 40,
    parameter int unsigned CNT_W  = $clog2(WINDOW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic [NLANE-1:0] inc_onehot,
    input  logic             clear,
    output logic [CNT_W-1:0] max_next
);
    logic [CNT_W-1:0] cnt [NLANE];
    logic [CNT_W-1:0] nxt [NLANE];

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        // Count including this cycle's vote for this lane.
        always_comb nxt[g] = cnt[g] + CNT_W'(inc_en && inc_onehot[g]);

        // Hold the lane's votes; start from zero at each new window.
        always_ff @(posedge clk) begin
            if (!rst_n)      cnt[g] <= '0;
            else if (clear)  cnt[g] <= '0;
            else if (inc_en) cnt[g] <= nxt[g];
        end

        // R7: the counters are cleared before a window's worth of votes.
        p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[g] < CNT_W'(WINDOW));
    end

    // Largest count over all lanes, including this cycle's vote.
    always_comb begin
        max_next = '0;
        for (int i = 0; i < NLANE; i++)
            if (nxt[i] > max_next) max_next = nxt[i];
    end
endmodule

// File: rtl/beacon_vote_detector.sv
// Module: top of the beacon vote detector. Every accepted symbol names a
// winning lane, and that lane gets a vote. After WINDOW symbols, the highest
// vote count is compared with the threshold, and a second detection sets sync.
// Assumes the samples are valid whenever sym_valid is high.
module beacon_vote_detector
    import bvd_pkg::*;
#(
    parameter int unsigned WINDOW = 40,
    parameter int unsigned CNT_W  = $clog2(WINDOW + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sym_valid,
    input  logic [NLANE*SAMP_W-1:0] sym_samples,
    input  logic [CNT_W-1:0]        vote_threshold,
    output logic                    win_valid,
    output logic [IDX_W-1:0]        win_idx,
    output logic [NLANE-1:0]        win_onehot,
    output logic                    beacon_det,
    output logic                    sync_locked
);
    localparam int unsigned SCNT_W = $clog2(WINDOW);

    logic [RND_W-1:0]  rnd;
    logic [NLANE-1:0]  tie_mask;
    logic [IDX_W-1:0]  pick;
    logic [NLANE-1:0]  pick_oh;
    logic [CNT_W-1:0]  max_next;
    logic [SCNT_W-1:0] sym_cnt;
    logic              close;
    logic              hit;
    logic [1:0]        det_cnt;
    win_t              win_q;

    bvd_lfsr #(.SEED(8'hA5)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .adv(sym_valid), .state(rnd)
    );

    bvd_argmax u_argmax (
        .samples(sym_samples), .rnd(rnd), .tie_mask(tie_mask), .pick(pick)
    );

    // One-hot form of the lane picked this cycle.
    always_comb pick_oh = NLANE'(1) << pick;

    // The window closes on its last symbol; a hit needs a count above threshold.
    always_comb begin
        close = sym_valid && (sym_cnt == SCNT_W'(WINDOW - 1));
        hit   = close && (max_next > vote_threshold);
    end

    bvd_vote_bank #(.WINDOW(WINDOW), .CNT_W(CNT_W)) u_votes (
        .clk(clk), .rst_n(rst_n), .inc_en(sym_valid), .inc_onehot(pick_oh),
        .clear(close), .max_next(max_next)
    );

    // Count accepted symbols within the current window.
    always_ff @(posedge clk) begin
        if (!rst_n)         sym_cnt <= '0;
        else if (close)     sym_cnt <= '0;
        else if (sym_valid) sym_cnt <= sym_cnt + 1'b1;
    end

    // Register the winner; the index holds through idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q.valid <= sym_valid;
            if (sym_valid) begin
                win_q.idx    <= pick;
                win_q.onehot <= pick_oh;
            end
        end
    end

    // Detection pulse, saturating detection count and sticky sync flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beacon_det  <= 1'b0;
            det_cnt     <= '0;
            sync_locked <= 1'b0;
        end else begin
            beacon_det <= hit;
            if (hit && det_cnt != 2'd2) det_cnt <= det_cnt + 1'b1;
            if (hit && det_cnt != 2'd0) sync_locked <= 1'b1;
        end
    end

    assign win_valid  = win_q.valid;
    assign win_idx    = win_q.idx;
    assign win_onehot = win_q.onehot;

    // R3: the picked lane is always one of the lanes tied at the maximum.
    p_pick_tied_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> tie_mask[pick]);
    // R5: the one-hot output has exactly the indexed bit set.
    p_onehot_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> ($countones(win_onehot) == 1 && win_onehot[win_idx]));
    // R6: a detection only follows an accepted symbol.
    p_det_after_sym_r6: assert property (@(posedge clk) disable iff (!rst_n)
        beacon_det |-> $past(sym_valid));
    // R6: the detection pulse lasts a single cycle.
    p_det_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        beacon_det |=> !beacon_det);
    // R8: once set, sync stays set until reset.
    p_sync_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_locked |=> sync_locked);
endmodule

// File: tb/beacon_vote_detector_tb_top.sv
`timescale 1ns/1ps
// Bench: random and directed symbol windows, checked against a model built
// from the requirements.
module beacon_vote_detector_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sym_valid;
    logic [31:0] sym_samples;
    logic [5:0]  vote_threshold;
    logic        win_valid;
    logic [2:0]  win_idx;
    logic [7:0]  win_onehot;
    logic        beacon_det;
    logic        sync_locked;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Model state
    logic [7:0] m_rnd;
    int         m_votes [8];
    int         m_scnt;
    int         m_dets;
    logic [2:0] m_idx;

    always #2.5 clk = ~clk;

    beacon_vote_detector dut_i (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid),
        .sym_samples(sym_samples), .vote_threshold(vote_threshold),
        .win_valid(win_valid), .win_idx(win_idx), .win_onehot(win_onehot),
        .beacon_det(beacon_det), .sync_locked(sync_locked)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rnd_next(input logic [7:0] r);
        return {r[6:0], r[7] ^ r[5] ^ r[4] ^ r[3]};
    endfunction

    // R2/R3 model: tied lanes in index order, choose the (r mod n)-th.
    function automatic logic [2:0] exp_winner(input logic [31:0] s, input logic [7:0] r);
        int mx = 0, n = 0, k, seen = 0;
        logic [2:0] w = 3'd0;
        for (int i = 0; i < 8; i++) if (int'(s[4*i +: 4]) > mx) mx = int'(s[4*i +: 4]);
        for (int i = 0; i < 8; i++) if (int'(s[4*i +: 4]) == mx) n++;
        k = int'(r) % n;
        for (int i = 0; i < 8; i++) begin
            if (int'(s[4*i +: 4]) == mx) begin
                if (seen == k) w = 3'(i);
                seen++;
            end
        end
        return w;
    endfunction

    task automatic model_reset();
        m_rnd = 8'hA5; m_scnt = 0; m_dets = 0; m_idx = 3'd0;
        for (int i = 0; i < 8; i++) m_votes[i] = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sym_valid = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        model_reset();
        // R1: reset state
        chk(win_valid == 0, "R1", "win_valid", int'(win_valid), 0);
        chk(win_idx == 0 && win_onehot == 0, "R1", "win_idx/onehot",
            int'(win_onehot), 0);
        chk(beacon_det == 0, "R1", "beacon_det", int'(beacon_det), 0);
        chk(sync_locked == 0, "R1", "sync_locked", int'(sync_locked), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        sym_valid = 1'b0;
        sym_samples = $urandom;
        @(posedge clk); #1;
        // R4: an idle cycle leaves the winner outputs unchanged
        chk(win_valid == 0, "R4", "win_valid idle", int'(win_valid), 0);
        chk(win_idx == m_idx, "R4", "win_idx held", int'(win_idx), int'(m_idx));
        chk(beacon_det == 0, "R4", "beacon_det idle", int'(beacon_det), 0);
    endtask

    task automatic send_sym(input logic [31:0] s);
        logic [2:0] w;
        bit exp_det;
        int mx;
        @(negedge clk);
        sym_valid = 1'b1;
        sym_samples = s;
        w = exp_winner(s, m_rnd);
        m_rnd = rnd_next(m_rnd);
        m_votes[w]++;
        m_scnt++;
        exp_det = 1'b0;
        if (m_scnt == 40) begin
            mx = 0;
            for (int i = 0; i < 8; i++) if (m_votes[i] > mx) mx = m_votes[i];
            exp_det = (mx > int'(vote_threshold));
            for (int i = 0; i < 8; i++) m_votes[i] = 0;
            m_scnt = 0;
            if (exp_det) m_dets++;
        end
        m_idx = w;
        @(posedge clk); #1;
        sym_valid = 1'b0;
        // R2 R3 R5: winner index, one-hot form and valid pulse
        chk(win_valid == 1, "R5", "win_valid", int'(win_valid), 1);
        chk(win_idx == w, "R3", "win_idx", int'(win_idx), int'(w));
        chk(win_onehot == (8'd1 << w), "R5", "win_onehot", int'(win_onehot),
            int'(8'd1 << w));
        // R6 R7: window decision
        chk(beacon_det == exp_det, "R6", "beacon_det", int'(beacon_det), int'(exp_det));
        // R8: sync after two detections
        chk(sync_locked == (m_dets >= 2), "R8", "sync_locked", int'(sync_locked),
            int'(m_dets >= 2));
    endtask

    // One window where lane `lane` is always a unique maximum (R2).
    task automatic directed_window(input int lane, input int thr);
        logic [31:0] s;
        vote_threshold = 6'(thr);
        for (int n = 0; n < 40; n++) begin
            s = $urandom & 32'hEEEE_EEEE;
            s[4*lane +: 4] = 4'hF;
            send_sym(s);
            if (n % 7 == 3) idle_cycle();
        end
    endtask

    // One window of narrow-range samples so that ties are frequent (R3).
    task automatic tie_window(input int thr, input bit all_zero);
        logic [31:0] s;
        vote_threshold = 6'(thr);
        for (int n = 0; n < 40; n++) begin
            s = '0;
            if (!all_zero)
                for (int i = 0; i < 8; i++) s[4*i +: 4] = 4'(12 + ($urandom % 4));
            send_sym(s);
            if ($urandom % 5 == 0) idle_cycle();
        end
    endtask

    initial begin
        void'($urandom(32'd7321));
        rst_n = 1'b0; sym_valid = 1'b0; sym_samples = '0; vote_threshold = 6'd0;
        model_reset();
        do_reset();
        directed_window(3, 39);   // R6: 40 > 39 detects
        directed_window(5, 40);   // R6: equal to threshold, no detect
        tie_window(5, 1'b0);      // R3 ties; R7 fresh counters
        tie_window(4, 1'b1);      // R3: all eight tied
        directed_window(0, 20);   // R8: a further detection
        for (int w = 0; w < 4; w++) tie_window(int'($urandom % 9), 1'b0);
        do_reset();               // R1: sync cleared again
        tie_window(3, 1'b0);
        directed_window(7, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(5 * 100000);
        if (!done) begin
            n_vec++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule